// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block is a synchronous bus master that turns one request at a time from a processor-side port into a timed cycle on a memory bus. Every operation has three phases. The first phase puts the address on the bus and raises the strobe. The second phase waits for the memory. The third phase ends the operation: it captures read data and releases the strobe. A slow memory stretches the second phase by holding its active-low ready input high.

A read request with the burst flag set runs as one transaction of four back-to-back read operations. The address steps by one word between operations. Each captured word is presented on the read-data port with a one-cycle valid pulse. A single done pulse marks the end of the whole transaction. A busy flag is high while a transaction runs. The processor side issues a new request only while busy is low, and the block drops any request that arrives while busy is high.

Top module: `mem_bus_seq`

## Requirements
- R1: During and right after reset, both strobes, the write-data output enable, busy and done are all low.
- R2: A zero-wait read raises the read strobe for exactly three clocks, starting the cycle after the request is sampled. The request address is on the bus from the first of those clocks. The read data bus is captured at the end of the third clock.
- R3: A write keeps the request address on the bus and the latched write data on the bus, with the output enable and the write strobe high, for exactly three clocks at zero wait. Changing the request inputs during the cycle has no effect on the bus.
- R4: Each clock in which ready is sampled high during the wait phase adds one clock to the operation.
- R5: Ready is ignored in the address phase and the end phase, so a ready held low all the time still gives three-clock operations.
- R6: A burst read runs four operations back to back. Operation k (k = 0..3) drives base address + 4*k, with 4-byte words. Each operation ends with an rd_valid pulse carrying that word.
- R7: Busy is high from the clock after acceptance until the end phase of the last operation. A request raised while busy is high is dropped: it causes no bus activity, neither then nor afterwards.
- R8: The read and write strobes are never high together. The write-data output enable is high only while the write strobe is high.
- R9: Done is a one-clock pulse, one clock after the last operation's end phase, in the same clock that busy first reads low.
- R10: The burst flag is ignored on writes: a write with the flag set runs as a single three-phase operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-word burst read when set on a read |
| req_addr | input | AW | Byte address of the first byte |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock end-of-transaction pulse |
| rd_data | output | DW | Last captured read word |
| rd_valid | output | 1 | One-clock pulse per captured word |
| bus_addr | output | AW | Memory address bus |
| bus_wdata | output | DW | Memory data bus, outgoing |
| bus_wdata_oe | output | 1 | Output enable for bus_wdata |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_rdata | input | DW | Memory data bus, incoming |
| bus_ready_n | input | 1 | Active-low ready from memory |

## Verification
The bench measures strobe length against the wait count. A design that samples ready in the wrong phase runs two-clock or four-clock operations, and a design that ignores ready cuts the access short. In bursts it checks the address of every operation and the timing of each word valid. A missing increment, or a done pulse raised after the first word, shows up as a wrong address or an early done. It also raises a request in the middle of a transaction, sets the burst flag on a write, and changes the write data after acceptance. A design that queues requests, bursts on writes or drives unlatched data then shows extra strobes or a corrupted bus.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_WAIT = 2'd2,
        PH_END  = 2'd3
    } phase_e;
endpackage

// File: rtl/mbs_phase_ctrl.sv
module mbs_phase_ctrl
    import mbs_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic req_burst,
    input  logic bus_ready_n,
    output logic accept,
    output logic step,
    output logic capture,
    output logic busy,
    output logic done,
    output logic rd_stb,
    output logic wr_stb,
    output logic wdata_oe
);
    localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BURST_LEN - 1);

    typedef struct packed {
        phase_e         ph;
        logic           wr;
        logic           burst;
        logic [CW-1:0]  idx;
        logic           done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        accept     = 1'b0;
        step       = 1'b0;
        capture    = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    accept      = 1'b1;
                    ctl_d.ph    = PH_ADDR;
                    ctl_d.wr    = req_write;
                    ctl_d.burst = req_burst & ~req_write;
                    ctl_d.idx   = '0;
                end
            end
            PH_ADDR: ctl_d.ph = PH_WAIT;
            PH_WAIT: begin
                if (!bus_ready_n) ctl_d.ph = PH_END;
            end
            default: begin
                capture = ~ctl_q.wr;
                if (ctl_q.burst && ctl_q.idx != LAST_IDX) begin
                    step      = 1'b1;
                    ctl_d.idx = ctl_q.idx + 1'b1;
                    ctl_d.ph  = PH_ADDR;
                end else begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, wr: 1'b0, burst: 1'b0, idx: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = (ctl_q.ph != PH_IDLE);
    assign done     = ctl_q.done;
    assign rd_stb   = busy & ~ctl_q.wr;
    assign wr_stb   = busy & ctl_q.wr;
    assign wdata_oe = wr_stb;

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
    assert_wait_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_WAIT && bus_ready_n) |=> (ctl_q.ph == PH_WAIT));
    assert_busy_from_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/mbs_addr_gen.sv
module mbs_addr_gen #(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          step,
    input  logic [AW-1:0] req_addr,
    output logic [AW-1:0] bus_addr
);
    localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (accept)    addr_d = req_addr;
        else if (step) addr_d = addr_q + STRIDE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign bus_addr = addr_q;

    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !step) |=> $stable(bus_addr));
endmodule

// File: rtl/mbs_data_path.sv
module mbs_data_path #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          req_write,
    input  logic          capture,
    input  logic          wdata_oe,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    typedef struct packed {
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvld;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d      = dp_q;
        dp_d.rvld = capture;
        if (accept && req_write) dp_d.wdata = req_wdata;
        if (capture)             dp_d.rdata = bus_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign bus_wdata = dp_q.wdata;
    assign rd_data   = dp_q.rdata;
    assign rd_valid  = dp_q.rvld;

    assert_wdata_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_oe && $past(wdata_oe)) |-> $stable(bus_wdata));
    assert_no_capture_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_oe |-> !capture);
endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq #(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready_n
);
    localparam int WORD_BYTES = DW / 8;

    logic accept, step, capture;

    mbs_phase_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .bus_ready_n(bus_ready_n),
        .accept(accept), .step(step), .capture(capture),
        .busy(busy), .done(done),
        .rd_stb(bus_rd), .wr_stb(bus_wr), .wdata_oe(bus_wdata_oe)
    );

    mbs_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .step(step),
        .req_addr(req_addr), .bus_addr(bus_addr)
    );

    mbs_data_path #(.DW(DW)) u_data (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .req_write(req_write), .capture(capture),
        .wdata_oe(bus_wdata_oe),
        .req_wdata(req_wdata), .bus_rdata(bus_rdata),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/test_mem_bus_seq.sv
module test_mem_bus_seq;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic busy, done, rd_valid, bus_wdata_oe, bus_rd, bus_wr, bus_ready_n;
    logic [DW-1:0] rd_data, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int errors = 0;
    int waits = 0;
    bit force_rdy = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mem_bus_seq #(.AW(AW), .DW(DW), .BURST_LEN(4)) i_mem_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_burst(req_burst),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .rd_valid(rd_valid),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_ready_n(bus_ready_n)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'h5A00, ~a};
    endfunction

    // memory model: ready after 'waits' wait-phase clocks
    logic stb, prev_stb, op_start;
    logic [AW-1:0] prev_addr;
    int cnt;
    assign stb = bus_rd | bus_wr;
    assign op_start = stb && (!prev_stb || bus_addr != prev_addr);
    assign bus_ready_n = force_rdy ? 1'b0 : !(stb && !op_start && cnt >= 1 + waits);
    assign bus_rdata = pat(bus_addr);

    always @(posedge clk) begin
        prev_stb  <= stb;
        prev_addr <= bus_addr;
        if (op_start)  cnt <= 1;
        else if (stb)  cnt <= cnt + 1;
        else           cnt <= 0;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_txn(input bit wr, input bit bst, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int w, input bit frc,
                          input bit poke, input string tg);
        int ops = (bst && !wr) ? 4 : 1;
        int len = 3 + w;
        int tot = ops * len;
        int rd_cnt = 0, wr_cnt = 0, both = 0, oe_bad = 0, busy_bad = 0;
        int addr_bad = 0, done_cnt = 0, done_cyc = -1, vld_cnt = 0, vld_bad = 0;
        int extra = 0;
        waits = w;
        force_rdy = frc;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_burst = bst; req_addr = a; req_wdata = wd;
        for (int c = 1; c <= tot + 1; c++) begin
            @(negedge clk);
            if (c == 1) begin req_valid = 1'b0; req_wdata = ~wd; req_addr = a + 16'h40; end
            if (poke && c == 2) begin req_valid = 1'b1; req_write = !wr; req_burst = 1'b0; end
            if (poke && c == 3) req_valid = 1'b0;
            if (bus_rd) rd_cnt++;
            if (bus_wr) wr_cnt++;
            if (bus_rd && bus_wr) both++;
            if (bus_wdata_oe != (wr && c <= tot)) oe_bad++;
            if (wr && c <= tot && bus_wdata != wd) oe_bad++;
            if (busy != (c <= tot)) busy_bad++;
            if (c <= tot && bus_addr != a + AW'(4 * ((c - 1) / len))) addr_bad++;
            if (done) begin done_cnt++; done_cyc = c; end
            if (rd_valid) begin
                vld_cnt++;
                if (c != vld_cnt * len + 1 || rd_data != pat(a + AW'(4 * (vld_cnt - 1)))) vld_bad++;
            end
        end
        for (int e = 0; e < 3; e++) begin
            @(negedge clk);
            if (busy || bus_rd || bus_wr || done) extra++;
        end
        force_rdy = 1'b0;
        check(rd_cnt == (wr ? 0 : tot), {tg, " R2 R4 read strobe clocks"}, 64'(rd_cnt), 64'(wr ? 0 : tot));
        check(wr_cnt == (wr ? tot : 0), {tg, " R3 R10 write strobe clocks"}, 64'(wr_cnt), 64'(wr ? tot : 0));
        check(both == 0 && oe_bad == 0, {tg, " R8 R3 strobe/oe/wdata"}, 64'(both + oe_bad), 64'd0);
        check(addr_bad == 0, {tg, " R6 R2 address per operation"}, 64'(addr_bad), 64'd0);
        check(busy_bad == 0, {tg, " R7 busy window"}, 64'(busy_bad), 64'd0);
        check(done_cnt == 1 && done_cyc == tot + 1, {tg, " R9 done timing"}, 64'(done_cyc), 64'(tot + 1));
        check(vld_cnt == (wr ? 0 : ops) && vld_bad == 0, {tg, " R6 read words"},
              64'(vld_cnt * 256 + vld_bad), 64'((wr ? 0 : ops) * 256));
        check(extra == 0, {tg, " R7 no activity after done"}, 64'(extra), 64'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_rd && !bus_wr && !bus_wdata_oe && !busy && !done, "R1 in reset",
              {59'd0, bus_rd, bus_wr, bus_wdata_oe, busy, done}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_rd && !bus_wr && !bus_wdata_oe && !busy && !done, "R1 after reset",
              {59'd0, bus_rd, bus_wr, bus_wdata_oe, busy, done}, 64'd0);
    endtask

    initial begin
        test_reset();
        do_txn(1'b0, 1'b0, 16'h0100, 32'h0,        0, 1'b0, 1'b0, "read w0");
        do_txn(1'b0, 1'b0, 16'h0204, 32'h0,        0, 1'b1, 1'b0, "read ready-held R5");
        do_txn(1'b0, 1'b0, 16'h0308, 32'h0,        2, 1'b0, 1'b0, "read w2");
        do_txn(1'b1, 1'b0, 16'h0410, 32'hDEADBEEF, 0, 1'b0, 1'b0, "write w0");
        do_txn(1'b1, 1'b0, 16'h0514, 32'h12345678, 3, 1'b0, 1'b0, "write w3");
        do_txn(1'b0, 1'b1, 16'h0600, 32'h0,        0, 1'b0, 1'b0, "burst w0");
        do_txn(1'b0, 1'b1, 16'h0FF8, 32'h0,        1, 1'b0, 1'b0, "burst w1");
        do_txn(1'b0, 1'b1, 16'h0720, 32'h0,        0, 1'b1, 1'b0, "burst ready-held R5");
        do_txn(1'b1, 1'b1, 16'h0800, 32'hA5A5C3C3, 0, 1'b0, 1'b0, "write burst-flag R10");
        do_txn(1'b0, 1'b0, 16'h0900, 32'h0,        1, 1'b0, 1'b1, "read with poke R7");
        do_txn(1'b1, 1'b0, 16'h0A00, 32'h0F0F0F0F, 0, 1'b0, 1'b1, "write with poke R7");
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule